// File: doc/BRIEF.md
# Flash Memory Protection Checker

This block rules on every flash operation request before it reaches the array. A request names an operation (read, program, erase), an erase kind (single page or whole bank), a partition (the data partition or one of three info types), a bank, a page, a starting word offset inside the program window and a word count. The block answers one cycle after accepting the request. The answer is a grant or a deny, plus the scramble, ECC and high-endurance attribute bits that apply to a granted access.

Permissions live in configuration registers loaded through a simple write port. The data partition is covered by a set of page-range regions with a default fallback. Each info page in each bank has its own attribute word. Each bank has its own bank-erase enable. Every permission field is a 4-bit multi-bit boolean. A deny raises a one-cycle error pulse and sets a sticky status flag that stays set until it is cleared.

The control is a two-state machine. `ST_IDLE` holds `req_ready` high. An accepted request moves it to `ST_RESP`, where the registered decision is presented for exactly one cycle. It then returns to `ST_IDLE` unconditionally.

Top module: `flash_mp_guard`

## Requirements
- R1: `req_ready` is high in `ST_IDLE`. A request accepted on an edge (`req_valid` && `req_ready`) produces `resp_valid` high for exactly the next cycle, and `req_ready` is low during that cycle.
- R2: A permission field is true only when it holds the code 4'hA. Any other value, including corrupted codes such as 4'hB, counts as false. A region whose enable is not 4'hA therefore takes no part in matching.
- R3: For a data-partition access (partition code 0), the global page is bank*16+page. Among enabled regions whose range [base, base+span) contains that page, the lowest index decides read, program and page-erase permission. A granted access reports that region's high-endurance flag.
- R4: A data-partition access that matches no enabled region uses the default region's read, program and erase permissions, and reports high-endurance 0.
- R5: Info partition codes 1, 2 and 3 select info types 0, 1 and 2. Each type has 4, 2 and 1 valid pages per bank respectively; a page beyond that size is denied. An access is granted only when the page's enable and its operation permission are both true. A grant reports that page's scramble, ECC and high-endurance flags.
- R6: A bank erase (`req_bank_erase`=1 with op erase) is granted only on partition code 0 or 1, and only when the bank's bit in the bank-erase register is 1. Region and page permissions are not consulted, and its attributes read 0.
- R7: A read or program is denied when the word count is 0, or when offset+count exceeds the 8-word program window.
- R8: Operation code 3 is denied. The operation codes are 0 read, 1 program and 2 erase.
- R9: A denied response raises `prot_err` in the same cycle as `resp_valid`. `err_status` becomes 1 on that same edge and holds until an `err_clr` cycle. A new deny in the same cycle as a clear keeps it set.
- R10: Out of reset every permission is false, so every request is denied. A denied response reports all attribute bits as 0.
- R11: The configuration map is as follows.
  - Region i permissions sit at address 2i, with fields [3:0] enable, [7:4] read, [11:8] program, [15:12] erase and [19:16] high-endurance.
  - Region i range sits at 2i+1, with [15:0] base page and [31:16] span.
  - The default region is at 0x20, with [3:0] read, [7:4] program and [11:8] erase.
  - The bank-erase bits are at 0x21.
  - Info page words are at 0x40+(bank*3+type)*4+page, with [3:0] enable, [7:4] read, [11:8] program, [15:12] erase, [19:16] scramble, [23:20] ECC and [27:24] high-endurance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Checker can accept a request |
| req_op | input | 2 | Operation: 0 read, 1 program, 2 erase |
| req_bank_erase | input | 1 | Erase kind: 1 whole bank, 0 single page |
| req_part | input | 2 | Partition: 0 data, 1..3 info types 0..2 |
| req_bank | input | 1 | Bank index |
| req_page | input | 4 | Page within the bank |
| req_wofs | input | 3 | Start word offset inside the program window |
| req_count | input | 4 | Number of words |
| resp_valid | output | 1 | Decision valid |
| resp_grant | output | 1 | 1 grant, 0 deny |
| resp_scr | output | 1 | Scramble attribute of the access |
| resp_ecc | output | 1 | ECC attribute of the access |
| resp_he | output | 1 | High-endurance attribute of the access |
| prot_err | output | 1 | One-cycle pulse on a denied response |
| err_clr | input | 1 | Clears the sticky error flag |
| err_status | output | 1 | Sticky protection-error flag |

## Verification
The hardest case to reach from the ports is overlapping regions that disagree. The lowest-index rule only shows when two enabled regions contain the same page with opposite permissions. A related case is a region silenced by a corrupted enable code, so that the next region or the default takes over. The stimulus programs two regions that overlap on pages 4 and 5 with mirrored read and program permissions. It probes pages inside the overlap, inside only one region and outside both. It then rewrites the winning region's enable with a non-true code and repeats the probes. Info-type size limits are reached by loading storage words that lie past a type's valid pages with all-true values, so only the size rule can deny those requests.

// File: rtl/flash_mp_pkg.sv
package flash_mp_pkg;

    localparam logic [3:0] MB_TRUE  = 4'hA;
    localparam logic [3:0] MB_FALSE = 4'h5;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_NONE  = 2'd3
    } mp_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } mp_state_e;

    typedef struct packed {
        logic [15:0] span;
        logic [15:0] base;
        logic [3:0]  he;
        logic [3:0]  er;
        logic [3:0]  pg;
        logic [3:0]  rd;
        logic [3:0]  en;
    } mp_region_t;

    typedef struct packed {
        logic [3:0] he;
        logic [3:0] ecc;
        logic [3:0] scr;
        logic [3:0] er;
        logic [3:0] pg;
        logic [3:0] rd;
        logic [3:0] en;
    } mp_info_t;

    typedef struct packed {
        logic [3:0] er;
        logic [3:0] pg;
        logic [3:0] rd;
    } mp_dflt_t;

    // Only the exact true code enables; everything else fails closed.
    function automatic logic mb_on(input logic [3:0] v);
        return v == MB_TRUE;
    endfunction

    // Valid pages of info type t: the largest type halves per step, at least one.
    function automatic int info_size(input int t, input int maxp);
        int s;
        s = maxp >> t;
        return (s < 1) ? 1 : s;
    endfunction

endpackage

// File: rtl/flash_mp_cfg.sv
module flash_mp_cfg
    import flash_mp_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int NUM_BANKS   = 2,
    parameter int INFO_TYPES  = 3,
    parameter int INFO_PAGES  = 4,
    parameter int AW          = 8,
    parameter int DW          = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [AW-1:0]                     cfg_addr,
    input  logic [DW-1:0]                     cfg_wdata,
    output mp_region_t [NUM_REGIONS-1:0]      regions,
    output mp_dflt_t                          dflt,
    output logic [NUM_BANKS-1:0]              bank_erase,
    output mp_info_t [NUM_BANKS*INFO_TYPES*INFO_PAGES-1:0] info
);

    localparam int NUM_INFO   = NUM_BANKS * INFO_TYPES * INFO_PAGES;
    localparam int DFLT_ADDR  = 'h20;
    localparam int BANK_ADDR  = 'h21;
    localparam int INFO_BASE  = 'h40;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGIONS; i++) begin
                regions[i] <= '{span: 16'd0, base: 16'd0, he: MB_FALSE, er: MB_FALSE,
                                pg: MB_FALSE, rd: MB_FALSE, en: MB_FALSE};
            end
            dflt       <= '{er: MB_FALSE, pg: MB_FALSE, rd: MB_FALSE};
            bank_erase <= '0;
            for (int k = 0; k < NUM_INFO; k++) begin
                info[k] <= '{he: MB_FALSE, ecc: MB_FALSE, scr: MB_FALSE, er: MB_FALSE,
                             pg: MB_FALSE, rd: MB_FALSE, en: MB_FALSE};
            end
        end else if (cfg_we) begin
            for (int i = 0; i < NUM_REGIONS; i++) begin
                if (cfg_addr == AW'(2 * i)) begin
                    regions[i].en <= cfg_wdata[3:0];
                    regions[i].rd <= cfg_wdata[7:4];
                    regions[i].pg <= cfg_wdata[11:8];
                    regions[i].er <= cfg_wdata[15:12];
                    regions[i].he <= cfg_wdata[19:16];
                end
                if (cfg_addr == AW'(2 * i + 1)) begin
                    regions[i].base <= cfg_wdata[15:0];
                    regions[i].span <= cfg_wdata[31:16];
                end
            end
            if (cfg_addr == AW'(DFLT_ADDR)) begin
                dflt.rd <= cfg_wdata[3:0];
                dflt.pg <= cfg_wdata[7:4];
                dflt.er <= cfg_wdata[11:8];
            end
            if (cfg_addr == AW'(BANK_ADDR)) begin
                bank_erase <= cfg_wdata[NUM_BANKS-1:0];
            end
            for (int k = 0; k < NUM_INFO; k++) begin
                if (cfg_addr == AW'(INFO_BASE + k)) begin
                    info[k] <= cfg_wdata[27:0];
                end
            end
        end
    end

endmodule

// File: rtl/flash_mp_region_match.sv
module flash_mp_region_match
    import flash_mp_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int GP_W        = 5
) (
    input  mp_region_t [NUM_REGIONS-1:0] regions,
    input  logic [GP_W-1:0]              gpage,
    output logic                         hit,
    output mp_region_t                   sel
);

    logic [NUM_REGIONS-1:0] in_rng;

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_rgn
        logic [16:0] lo, hi, gp;
        assign gp = 17'(gpage);
        assign lo = {1'b0, regions[i].base};
        assign hi = lo + {1'b0, regions[i].span};
        assign in_rng[i] = mb_on(regions[i].en) && (gp >= lo) && (gp < hi);
    end

    // Lowest index wins: scan from the top so lower indices overwrite.
    always_comb begin
        hit = |in_rng;
        sel = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (in_rng[i]) sel = regions[i];
        end
    end

endmodule

// File: rtl/flash_mp_info_lookup.sv
module flash_mp_info_lookup
    import flash_mp_pkg::*;
#(
    parameter int NUM_BANKS  = 2,
    parameter int INFO_TYPES = 3,
    parameter int INFO_PAGES = 4,
    parameter int BANK_W     = 1,
    parameter int TYPE_W     = 2,
    parameter int PAGE_W     = 4
) (
    input  mp_info_t [NUM_BANKS*INFO_TYPES*INFO_PAGES-1:0] info,
    input  logic [BANK_W-1:0] bank,
    input  logic [TYPE_W-1:0] type_idx,
    input  logic [PAGE_W-1:0] page,
    output logic              in_range,
    output mp_info_t          sel
);

    localparam int NUM_INFO = NUM_BANKS * INFO_TYPES * INFO_PAGES;

    always_comb begin
        int idx;
        in_range = (int'(bank) < NUM_BANKS) && (int'(type_idx) < INFO_TYPES) &&
                   (int'(page) < info_size(int'(type_idx), INFO_PAGES));
        idx = ((int'(bank) * INFO_TYPES) + int'(type_idx)) * INFO_PAGES + int'(page);
        sel = '0;
        if (in_range && idx < NUM_INFO) sel = info[idx];
    end

endmodule

// File: rtl/flash_mp_guard.sv
module flash_mp_guard
    import flash_mp_pkg::*;
#(
    parameter int NUM_REGIONS    = 4,
    parameter int NUM_BANKS      = 2,
    parameter int PAGES_PER_BANK = 16,
    parameter int INFO_TYPES     = 3,
    parameter int INFO_PAGES     = 4,
    parameter int PGM_WORDS      = 8,
    parameter int AW             = 8,
    parameter int DW             = 32,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int PAGE_W = $clog2(PAGES_PER_BANK),
    localparam int PART_W = $clog2(INFO_TYPES + 1),
    localparam int WOFS_W = $clog2(PGM_WORDS),
    localparam int CNT_W  = $clog2(PGM_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic              req_bank_erase,
    input  logic [PART_W-1:0] req_part,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [WOFS_W-1:0] req_wofs,
    input  logic [CNT_W-1:0]  req_count,
    output logic              resp_valid,
    output logic              resp_grant,
    output logic              resp_scr,
    output logic              resp_ecc,
    output logic              resp_he,
    output logic              prot_err,
    input  logic              err_clr,
    output logic              err_status
);

    localparam int NUM_INFO = NUM_BANKS * INFO_TYPES * INFO_PAGES;
    localparam int GP_W     = BANK_W + PAGE_W;

    mp_region_t [NUM_REGIONS-1:0] regions;
    mp_dflt_t                     dflt;
    logic [NUM_BANKS-1:0]         bank_erase;
    mp_info_t [NUM_INFO-1:0]      info;

    flash_mp_cfg #(
        .NUM_REGIONS(NUM_REGIONS), .NUM_BANKS(NUM_BANKS), .INFO_TYPES(INFO_TYPES),
        .INFO_PAGES(INFO_PAGES), .AW(AW), .DW(DW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .regions(regions), .dflt(dflt),
        .bank_erase(bank_erase), .info(info)
    );

    logic [GP_W-1:0] gpage;
    logic            rgn_hit;
    mp_region_t      rgn_sel;

    assign gpage = GP_W'(int'(req_bank) * PAGES_PER_BANK + int'(req_page));

    flash_mp_region_match #(.NUM_REGIONS(NUM_REGIONS), .GP_W(GP_W)) u_match (
        .regions(regions), .gpage(gpage), .hit(rgn_hit), .sel(rgn_sel)
    );

    logic [PART_W-1:0] info_type;
    logic              info_ok;
    mp_info_t          info_sel;

    assign info_type = PART_W'(req_part - 1'b1);

    flash_mp_info_lookup #(
        .NUM_BANKS(NUM_BANKS), .INFO_TYPES(INFO_TYPES), .INFO_PAGES(INFO_PAGES),
        .BANK_W(BANK_W), .TYPE_W(PART_W), .PAGE_W(PAGE_W)
    ) u_info (
        .info(info), .bank(req_bank), .type_idx(info_type), .page(req_page),
        .in_range(info_ok), .sel(info_sel)
    );

    logic unused_rgn_range;
    assign unused_rgn_range = ^{rgn_sel.base, rgn_sel.span};

    // ---------------- decision ----------------
    mp_op_e     op;
    logic       is_data, win_ok, bank_ok, allow, a_scr, a_ecc, a_he;
    logic [3:0] d_rd, d_pg, d_er, d_he;

    assign op      = mp_op_e'(req_op);
    assign is_data = (req_part == '0);
    assign win_ok  = (req_count != '0) && ((int'(req_wofs) + int'(req_count)) <= PGM_WORDS);
    assign bank_ok = (int'(req_bank) < NUM_BANKS) && bank_erase[req_bank];
    assign d_rd    = rgn_hit ? rgn_sel.rd : dflt.rd;
    assign d_pg    = rgn_hit ? rgn_sel.pg : dflt.pg;
    assign d_er    = rgn_hit ? rgn_sel.er : dflt.er;
    assign d_he    = rgn_hit ? rgn_sel.he : MB_FALSE;

    always_comb begin
        allow = 1'b0;
        unique case (op)
            OP_READ:  allow = win_ok && (is_data ? mb_on(d_rd)
                              : (info_ok && mb_on(info_sel.en) && mb_on(info_sel.rd)));
            OP_PROG:  allow = win_ok && (is_data ? mb_on(d_pg)
                              : (info_ok && mb_on(info_sel.en) && mb_on(info_sel.pg)));
            OP_ERASE: begin
                if (req_bank_erase) begin
                    allow = (is_data || req_part == PART_W'(1)) && bank_ok;
                end else begin
                    allow = is_data ? mb_on(d_er)
                          : (info_ok && mb_on(info_sel.en) && mb_on(info_sel.er));
                end
            end
            OP_NONE:  allow = 1'b0;
        endcase
    end

    always_comb begin
        a_scr = 1'b0;
        a_ecc = 1'b0;
        a_he  = 1'b0;
        if (allow && !(op == OP_ERASE && req_bank_erase)) begin
            if (is_data) begin
                a_he = mb_on(d_he);
            end else begin
                a_scr = mb_on(info_sel.scr);
                a_ecc = mb_on(info_sel.ecc);
                a_he  = mb_on(info_sel.he);
            end
        end
    end

    // ---------------- state machine ----------------
    mp_state_e state_q, state_d;
    logic      accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) state_d = ST_RESP;
            end
            ST_RESP: begin
                resp_valid = 1'b1;
                state_d    = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_grant <= 1'b0;
            resp_scr   <= 1'b0;
            resp_ecc   <= 1'b0;
            resp_he    <= 1'b0;
            prot_err   <= 1'b0;
            err_status <= 1'b0;
        end else begin
            prot_err <= accept && !allow;
            if (accept) begin
                resp_grant <= allow;
                resp_scr   <= a_scr;
                resp_ecc   <= a_ecc;
                resp_he    <= a_he;
            end
            if (accept && !allow) err_status <= 1'b1;
            else if (err_clr)     err_status <= 1'b0;
        end
    end

endmodule

// File: rtl/flash_mp_guard_sva.sv
module flash_mp_guard_sva (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic resp_valid,
    input logic resp_grant,
    input logic resp_scr,
    input logic resp_ecc,
    input logic resp_he,
    input logic prot_err,
    input logic err_clr,
    input logic err_status
);

    // R1: an accepted request is answered on the next cycle
    a_r1_accept_resp: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> resp_valid);

    // R1: the answer lasts a single cycle
    a_r1_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R1: no new request is taken while answering
    a_r1_busy: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    // R9: error pulse only accompanies a denied answer
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> resp_valid && !resp_grant);

    // R9: every denied answer carries the pulse
    a_r9_deny_flag: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_grant |-> prot_err);

    // R9: sticky flag is set alongside the pulse
    a_r9_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> err_status);

    // R9: sticky flag holds without a clear
    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        err_status && !err_clr |=> err_status);

    // R10: a denied answer exposes no attributes
    a_r10_deny_attrs: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_grant |-> !resp_scr && !resp_ecc && !resp_he);

endmodule

bind flash_mp_guard flash_mp_guard_sva u_sva (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_scr(resp_scr),
    .resp_ecc(resp_ecc), .resp_he(resp_he), .prot_err(prot_err),
    .err_clr(err_clr), .err_status(err_status)
);

// File: tb/test_flash_mp_guard.sv
module test_flash_mp_guard;

    localparam logic [3:0] T = 4'hA;
    localparam logic [3:0] F = 4'h5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic        req_bank_erase = 1'b0;
    logic [1:0]  req_part = '0;
    logic        req_bank = 1'b0;
    logic [3:0]  req_page = '0;
    logic [2:0]  req_wofs = '0;
    logic [3:0]  req_count = '0;
    logic        resp_valid, resp_grant, resp_scr, resp_ecc, resp_he, prot_err;
    logic        err_clr = 1'b0;
    logic        err_status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  g;
        logic  s;
        logic  e;
        logic  h;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    flash_mp_guard i_flash_mp_guard (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_bank_erase(req_bank_erase), .req_part(req_part),
        .req_bank(req_bank), .req_page(req_page), .req_wofs(req_wofs),
        .req_count(req_count), .resp_valid(resp_valid), .resp_grant(resp_grant),
        .resp_scr(resp_scr), .resp_ecc(resp_ecc), .resp_he(resp_he),
        .prot_err(prot_err), .err_clr(err_clr), .err_status(err_status)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pop expectations as answers appear.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sb.size() == 0) begin
                chk(8'h1, 8'h0, "R1 unexpected response");
            end else begin
                exp_t x;
                x = sb.pop_front();
                chk({3'b0, resp_grant, resp_scr, resp_ecc, resp_he, prot_err},
                    {3'b0, x.g, x.s, x.e, x.h, ~x.g}, x.tag);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] rperm(input logic [3:0] en, rd, pg, er, he);
        return {12'b0, he, er, pg, rd, en};
    endfunction

    function automatic logic [31:0] iword(input logic [3:0] en, rd, pg, er, scr, ecc, he);
        return {4'b0, he, ecc, scr, er, pg, rd, en};
    endfunction

    task automatic req(input logic [1:0] op, input logic be, input logic [1:0] part,
                       input logic bank, input logic [3:0] page, input logic [2:0] wofs,
                       input logic [3:0] cnt, input logic g, s, e, h, input string tag);
        exp_t x;
        x.g = g; x.s = s; x.e = e; x.h = h; x.tag = tag;
        sb.push_back(x);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_bank_erase = be; req_part = part;
        req_bank = bank; req_page = page; req_wofs = wofs; req_count = cnt;
        @(negedge clk);
        req_valid = 1'b0;
        chk({7'b0, req_ready}, 8'h0, "R1 ready low while answering");
        @(negedge clk);
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk({7'b0, err_status}, 8'h0, "R9 sticky cleared");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({7'b0, req_ready}, 8'h1, "R1 ready after reset");
        chk({7'b0, resp_valid}, 8'h0, "R10 no response after reset");
        chk({7'b0, err_status}, 8'h0, "R9 status clear after reset");

        // R10: everything denied out of reset
        req(0, 0, 0, 0, 4'd0, 0, 1, 0, 0, 0, 0, "R10 reset read denied");
        chk({7'b0, err_status}, 8'h1, "R9 sticky set on deny");
        clear_err();

        // R4: default region
        wr(8'h20, {20'b0, F, F, T});
        req(0, 0, 0, 0, 4'd3, 0, 1, 1, 0, 0, 0, "R4 default read grant");
        req(1, 0, 0, 0, 4'd3, 0, 1, 0, 0, 0, 0, "R4 default program deny");

        // R3/R11: overlapping regions
        wr(8'h00, rperm(T, F, T, T, T));
        wr(8'h01, {16'd4, 16'd2});
        wr(8'h02, rperm(T, T, F, F, F));
        wr(8'h03, {16'd4, 16'd4});
        req(0, 0, 0, 0, 4'd4, 0, 1, 0, 0, 0, 0, "R3 lowest region read deny");
        req(1, 0, 0, 0, 4'd4, 0, 1, 1, 0, 0, 1, "R3 lowest region program grant he");
        req(0, 0, 0, 0, 4'd7, 0, 1, 1, 0, 0, 0, "R3 second region read grant");
        req(1, 0, 0, 0, 4'd7, 0, 1, 0, 0, 0, 0, "R3 second region program deny");
        req(0, 0, 0, 0, 4'd9, 0, 1, 1, 0, 0, 0, "R4 outside regions default");
        req(2, 0, 0, 0, 4'd2, 0, 0, 1, 0, 0, 1, "R3 page erase via region R11");

        // R2: corrupted enable code
        wr(8'h00, rperm(4'hB, F, T, T, T));
        req(0, 0, 0, 0, 4'd4, 0, 1, 1, 0, 0, 0, "R2 bad enable skips region");
        req(1, 0, 0, 0, 4'd3, 0, 1, 0, 0, 0, 0, "R2 bad enable falls to default");

        // R3: bank 1 global page
        wr(8'h04, rperm(T, F, F, T, F));
        wr(8'h05, {16'd1, 16'd17});
        req(2, 0, 0, 1, 4'd1, 0, 0, 1, 0, 0, 0, "R3 bank1 page erase grant");
        req(2, 0, 0, 0, 4'd1, 0, 0, 0, 0, 0, 0, "R3 bank0 page erase default deny");

        // R7: program window
        req(0, 0, 0, 0, 4'd9, 5, 3, 1, 0, 0, 0, "R7 window edge fits");
        req(0, 0, 0, 0, 4'd9, 5, 4, 0, 0, 0, 0, "R7 window overrun");
        req(0, 0, 0, 0, 4'd9, 0, 0, 0, 0, 0, 0, "R7 zero count");
        req(0, 0, 0, 0, 4'd9, 0, 8, 1, 0, 0, 0, "R7 full window");
        req(0, 0, 0, 0, 4'd9, 0, 9, 0, 0, 0, 0, "R7 count above window");

        // R8
        req(3, 0, 0, 0, 4'd9, 0, 1, 0, 0, 0, 0, "R8 invalid op");

        // R5: info pages
        wr(8'h45, iword(T, T, F, F, T, F, T));
        req(0, 0, 2, 0, 4'd1, 0, 1, 1, 1, 0, 1, "R5 info read grant attrs");
        req(1, 0, 2, 0, 4'd1, 0, 1, 0, 0, 0, 0, "R5 info program deny");
        req(2, 0, 2, 0, 4'd1, 0, 0, 0, 0, 0, 0, "R5 info page erase deny");
        wr(8'h46, iword(T, T, T, T, T, T, T));
        req(0, 0, 2, 0, 4'd2, 0, 1, 0, 0, 0, 0, "R5 info type1 beyond size");
        wr(8'h4C, iword(F, T, T, T, T, T, T));
        req(0, 0, 1, 1, 4'd0, 0, 1, 0, 0, 0, 0, "R5 info page not enabled");
        wr(8'h4D, iword(T, T, F, F, F, T, F));
        req(0, 0, 1, 1, 4'd1, 0, 1, 1, 0, 1, 0, "R5 info bank1 ecc attr");
        wr(8'h48, iword(T, T, T, T, T, T, T));
        req(0, 0, 3, 0, 4'd0, 0, 1, 1, 1, 1, 1, "R5 info type2 page0");
        req(0, 0, 3, 0, 4'd1, 0, 1, 0, 0, 0, 0, "R5 info type2 beyond size");

        // R6: bank erase
        wr(8'h21, 32'h2);
        req(2, 1, 0, 1, 4'd0, 0, 0, 1, 0, 0, 0, "R6 data bank erase grant");
        req(2, 1, 0, 0, 4'd0, 0, 0, 0, 0, 0, 0, "R6 bank erase bit clear");
        req(2, 1, 1, 1, 4'd0, 0, 0, 1, 0, 0, 0, "R6 info type0 bank erase");
        req(2, 1, 2, 1, 4'd0, 0, 0, 0, 0, 0, 0, "R6 info type1 bank erase deny");
        req(2, 1, 3, 1, 4'd0, 0, 0, 0, 0, 0, 0, "R6 info type2 bank erase deny");

        chk({7'b0, err_status}, 8'h1, "R9 sticky after denies");
        clear_err();

        repeat (4) @(negedge clk);
        chk(8'(sb.size()), 8'h0, "R1 all responses seen");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule